// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Code Register

This block adds or subtracts two operands at 8-bit or 16-bit width and keeps an 8-bit condition code register up to date. Four operations are available: plain add, add including the held carry flag, plain subtract, and subtract including the held carry flag as a borrow. On a cycle with the strobe high, the operands, operation and width are taken in. On the next clock edge the registered result is published and the flag bits that the operation owns are written. Every other flag bit keeps the value it already had.

A per-operation write mask selects which flags change. Only 8-bit additions (plain or with carry) write the half-carry bit. Every other operation writes sign, zero, overflow and carry/borrow and leaves the half-carry as it was. The three control bits (S, X, I) are never written by arithmetic. The carry flag read by the chained operations is the registered one. This lets back-to-back strobes build a wider sum or difference one word at a time.

A two-state output machine shows when a result is fresh. `ST_IDLE` (no result this cycle) moves to `ST_PUBLISH` on the edge that captures a strobed operation (transition *accept*). `ST_PUBLISH` stays there on another strobe (transition *chain*) and goes back to `ST_IDLE` when no strobe is present (transition *drain*). Reset forces `ST_IDLE`.

Top module: `arith_flag_unit`

## Requirements
- R1: A synchronous active-high reset sets the flag register to 0xD0, clears the result and deasserts the output-valid flag. Flag bit layout from bit 7 to bit 0 is S, X, H, I, N, Z, V, C.
- R2: A strobe with operation code 0 (add), 1 (add with carry), 2 (subtract) or 3 (subtract with borrow) gives, one clock later, the result modulo 2^width with output-valid high. Width select 0 means 8-bit on the low operand bytes with result bits 15:8 zero. Width select 1 means 16-bit.
- R3: After an addition, C equals the carry out of the top bit. After a subtraction, C is 1 exactly when the subtraction needed a borrow, that is when the unsigned minuend is smaller than the subtrahend plus any borrow-in.
- R4: V is 1 after an addition whose operands share a sign that the result does not have. V is 1 after a subtraction whose operands differ in sign and whose result sign differs from the minuend's.
- R5: Z is 1 exactly when the result at the selected width is zero. N equals the top bit of the result at the selected width.
- R6: An 8-bit addition (code 0 or 1) writes H with the carry out of bit 3. Subtractions and 16-bit additions leave H unchanged.
- R7: Codes 1 and 3 add or subtract the C flag held before the operation. Codes 0 and 2 ignore it.
- R8: Bits S, X and I keep their reset value of 1 through every operation.
- R9: A cycle without the strobe leaves the flag register and result unchanged and drops output-valid on the next edge.
- R10: Worked cases: 8-bit 0xAA+0xBC gives 0x66 with H=1, N=0, Z=0, V=1, C=1 (flags 0xF3). 8-bit 0x40+0x40 gives 0x80 with N=1, V=1, C=0, Z=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Operation request for this cycle |
| op_i | input | 2 | 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow |
| wide_i | input | 1 | 0 selects 8-bit, 1 selects 16-bit |
| lhs_i | input | 16 | First operand (minuend for subtraction) |
| rhs_i | input | 16 | Second operand (subtrahend for subtraction) |
| result_o | output | 16 | Registered result |
| out_valid_o | output | 1 | High for one cycle per accepted strobe |
| ccr_o | output | 8 | Condition code register |

## Verification
The stated worked sums pin down each flag in one step, and sign-boundary pairs (0x7F+1, 0x80-1, 0x8000-1) separate V from C. Zero-producing pairs at both widths test Z. They also show whether an 8-bit result leaks a carry into the upper byte. Chains of carry- and borrow-using operations, with C first set and then cleared, tell the chained codes apart from the plain ones. They also show whether the carry in is the held flag. A 16-bit add and a subtract run while H is 1 and again while H is 0, to show that H is kept. A long run of random operations mixed with idle cycles is compared every clock against a behavioural integer model.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_ADC = 2'd1,
        OP_SUB = 2'd2,
        OP_SBC = 2'd3
    } arith_op_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PUBLISH = 1'b1
    } pub_state_e;

    localparam int CCR_W  = 8;
    localparam int FLAG_C = 0;
    localparam int FLAG_V = 1;
    localparam int FLAG_Z = 2;
    localparam int FLAG_N = 3;
    localparam int FLAG_I = 4;
    localparam int FLAG_H = 5;
    localparam int FLAG_X = 6;
    localparam int FLAG_S = 7;

    localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

    function automatic logic op_is_sub(arith_op_e op);
        return (op == OP_SUB) || (op == OP_SBC);
    endfunction

    function automatic logic op_uses_carry(arith_op_e op);
        return (op == OP_ADC) || (op == OP_SBC);
    endfunction

endpackage

// File: rtl/arith_lane.sv
module arith_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         half_o,
    output logic         ovf_o
);
    localparam int EXT_W = W + 1;

    logic [EXT_W-1:0] ext;
    logic [4:0]       nib;

    always_comb begin
        if (sub_i) begin
            ext = {1'b0, a_i} - {1'b0, b_i} - EXT_W'(cin_i);
        end else begin
            ext = {1'b0, a_i} + {1'b0, b_i} + EXT_W'(cin_i);
        end
        nib    = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]} + 5'(cin_i);
        sum_o  = ext[W-1:0];
        cout_o = ext[W];
        half_o = nib[4];
        if (sub_i) begin
            ovf_o = (a_i[W-1] != b_i[W-1]) && (ext[W-1] != a_i[W-1]);
        end else begin
            ovf_o = (a_i[W-1] == b_i[W-1]) && (ext[W-1] != a_i[W-1]);
        end
    end
endmodule

// File: rtl/flag_merge.sv
module flag_merge
    import arith_flag_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [CCR_W-1:0]  old_ccr_i,
    input  arith_op_e         op_i,
    input  logic              wide_i,
    input  logic [WIDE_W-1:0] sum_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    input  logic              half_i,
    output logic [CCR_W-1:0]  next_ccr_o
);
    logic [CCR_W-1:0] calc;
    logic [CCR_W-1:0] wmask;

    always_comb begin
        calc         = '0;
        calc[FLAG_C] = carry_i;
        calc[FLAG_V] = ovf_i;
        calc[FLAG_Z] = (sum_i == '0);
        calc[FLAG_N] = wide_i ? sum_i[WIDE_W-1] : sum_i[NARROW_W-1];
        calc[FLAG_H] = half_i;

        wmask         = '0;
        wmask[FLAG_C] = 1'b1;
        wmask[FLAG_V] = 1'b1;
        wmask[FLAG_Z] = 1'b1;
        wmask[FLAG_N] = 1'b1;
        wmask[FLAG_H] = !wide_i && !op_is_sub(op_i);

        next_ccr_o = (old_ccr_i & ~wmask) | (calc & wmask);
    end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import arith_flag_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              strobe_i,
    input  logic [1:0]        op_i,
    input  logic              wide_i,
    input  logic [WIDE_W-1:0] lhs_i,
    input  logic [WIDE_W-1:0] rhs_i,
    output logic [WIDE_W-1:0] result_o,
    output logic              out_valid_o,
    output logic [CCR_W-1:0]  ccr_o
);
    localparam int LANES = 2;

    arith_op_e        op;
    pub_state_e       state_q, state_d;
    logic [CCR_W-1:0] ccr_q, ccr_d;
    logic [WIDE_W-1:0] res_q;
    logic              wide_q;

    logic [WIDE_W-1:0] lane_sum [LANES];
    logic              lane_c   [LANES];
    logic              lane_v   [LANES];
    logic              lane_h   [LANES];

    logic              cin;
    logic [WIDE_W-1:0] sel_sum;
    logic              sel_c, sel_v, sel_h;

    assign op  = arith_op_e'(op_i);
    assign cin = op_uses_carry(op) && ccr_q[FLAG_C];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
        logic [LW-1:0] s;
        arith_lane #(.W(LW)) u_lane (
            .a_i   (lhs_i[LW-1:0]),
            .b_i   (rhs_i[LW-1:0]),
            .sub_i (op_is_sub(op)),
            .cin_i (cin),
            .sum_o (s),
            .cout_o(lane_c[g]),
            .half_o(lane_h[g]),
            .ovf_o (lane_v[g])
        );
        assign lane_sum[g] = WIDE_W'(s);
    end

    always_comb begin
        sel_sum = wide_i ? lane_sum[1] : lane_sum[0];
        sel_c   = wide_i ? lane_c[1]   : lane_c[0];
        sel_v   = wide_i ? lane_v[1]   : lane_v[0];
        sel_h   = lane_h[0];
    end

    flag_merge #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_merge (
        .old_ccr_i (ccr_q),
        .op_i      (op),
        .wide_i    (wide_i),
        .sum_i     (sel_sum),
        .carry_i   (sel_c),
        .ovf_i     (sel_v),
        .half_i    (sel_h),
        .next_ccr_o(ccr_d)
    );

    // Output machine: accept / chain into ST_PUBLISH, drain to ST_IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = strobe_i ? ST_PUBLISH : ST_IDLE;
            ST_PUBLISH: state_d = strobe_i ? ST_PUBLISH : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ccr_q  <= CCR_RESET;
            res_q  <= '0;
            wide_q <= 1'b0;
        end else if (strobe_i) begin
            ccr_q  <= ccr_d;
            res_q  <= sel_sum;
            wide_q <= wide_i;
        end
    end

    assign result_o    = res_q;
    assign out_valid_o = (state_q == ST_PUBLISH);
    assign ccr_o       = ccr_q;

    // R2: a strobe yields a published result on the next edge
    a_r2_publish: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_i |=> out_valid_o);

    // R9: idle cycles keep state and drop valid
    a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !strobe_i |=> (!out_valid_o && $stable(ccr_o) && $stable(result_o)));

    // R6: H survives subtraction and 16-bit work
    a_r6_half_kept: assert property (@(posedge clk_i) disable iff (rst_i)
        (strobe_i && (wide_i || op_is_sub(op))) |=> $stable(ccr_o[FLAG_H]));

    // R8: control bits are never written
    a_r8_ctrl_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_i |=> ($stable(ccr_o[FLAG_S]) && $stable(ccr_o[FLAG_X]) && $stable(ccr_o[FLAG_I])));

    // R3: plain 16-bit subtract borrows exactly when minuend is smaller
    a_r3_borrow16: assert property (@(posedge clk_i) disable iff (rst_i)
        (strobe_i && wide_i && op == OP_SUB) |=> (ccr_o[FLAG_C] == ($past(lhs_i) < $past(rhs_i))));

    // R5: N follows the top bit, Z follows an all-zero result
    a_r5_sign_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> ((ccr_o[FLAG_N] == (wide_q ? result_o[WIDE_W-1] : result_o[NARROW_W-1]))
                         && (ccr_o[FLAG_Z] == (result_o == '0))));

    // R2: narrow results never carry into the upper byte
    a_r2_narrow_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && !wide_q) |-> (result_o[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: tb/arith_flag_unit_test.sv
module arith_flag_unit_test;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        strobe_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic        wide_i = 1'b0;
    logic [15:0] lhs_i = '0;
    logic [15:0] rhs_i = '0;
    logic [15:0] result_o;
    logic        out_valid_o;
    logic [7:0]  ccr_o;

    int checks = 0;
    int errors = 0;
    int m_ccr;
    int m_res;
    bit finished = 0;

    always #5 clk_i = ~clk_i;

    arith_flag_unit uut (
        .clk_i(clk_i), .rst_i(rst_i), .strobe_i(strobe_i), .op_i(op_i),
        .wide_i(wide_i), .lhs_i(lhs_i), .rhs_i(rhs_i), .result_o(result_o),
        .out_valid_o(out_valid_o), .ccr_o(ccr_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model of one operation; updates m_ccr and m_res.
    task automatic model(int op, int wide, int a, int b);
        int w, msk, aa, bb, c, full, r, sa, sb, sr, nc;
        w   = wide ? 16 : 8;
        msk = (1 << w) - 1;
        aa  = a & msk;
        bb  = b & msk;
        c   = (op == 1 || op == 3) ? (m_ccr & 1) : 0;
        nc  = m_ccr;
        if (op < 2) begin
            full = aa + bb + c;
            r    = full & msk;
            nc   = (nc & ~1) | ((full >> w) & 1);
            if (!wide) nc = (nc & ~32) | ((((aa & 15) + (bb & 15) + c) >> 4) << 5);
        end else begin
            full = aa - bb - c;
            r    = full & msk;
            nc   = (nc & ~1) | ((full < 0) ? 1 : 0);
        end
        sa = (aa >> (w - 1)) & 1;
        sb = (bb >> (w - 1)) & 1;
        sr = (r  >> (w - 1)) & 1;
        nc = nc & ~2;
        if (op < 2 && sa == sb && sr != sa) nc = nc | 2;
        if (op >= 2 && sa != sb && sr != sa) nc = nc | 2;
        nc = (nc & ~4) | ((r == 0) ? 4 : 0);
        nc = (nc & ~8) | (sr << 3);
        m_ccr = nc;
        m_res = r;
    endtask

    // Drive at a negedge, check at the following negedge.
    task automatic do_op(string req, int op, int wide, int a, int b);
        strobe_i = 1'b1; op_i = op[1:0]; wide_i = wide[0];
        lhs_i = a[15:0]; rhs_i = b[15:0];
        model(op, wide, a, b);
        @(negedge clk_i);
        strobe_i = 1'b0;
        check({req, " result"}, int'(result_o), m_res);
        check({req, " flags"}, int'(ccr_o), m_ccr);
        check({req, " R2 valid"}, int'(out_valid_o), 1);
    endtask

    task automatic idle(string req);
        strobe_i = 1'b0;
        lhs_i = 16'hFFFF; rhs_i = 16'h1234; op_i = 2'd3;
        @(negedge clk_i);
        check({req, " R9 result hold"}, int'(result_o), m_res);
        check({req, " R9 flags hold"}, int'(ccr_o), m_ccr);
        check({req, " R9 valid low"}, int'(out_valid_o), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk_i);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        m_ccr = 'hD0; m_res = 0;
        repeat (3) @(negedge clk_i);
        rst_i = 1'b0;
        check("R1 reset flags", int'(ccr_o), 'hD0);
        check("R1 reset result", int'(result_o), 0);
        check("R1 reset valid", int'(out_valid_o), 0);

        // R10 worked case: 0xAA + 0xBC
        do_op("R10 aa+bc", 0, 0, 'hAA, 'hBC);
        check("R10 aa+bc result", int'(result_o), 'h66);
        check("R10 aa+bc flags R3 R4 R6", int'(ccr_o), 'hF3);
        // R10 worked case: 0x40 + 0x40
        do_op("R10 40+40", 0, 0, 'h40, 'h40);
        check("R10 40+40 result", int'(result_o), 'h80);
        check("R10 40+40 N V R4 R5", int'(ccr_o) & 'h0F, 'h0A);

        // R5 zero at 8 bits with carry out, upper byte must stay clear (R2)
        do_op("R5 zero8", 0, 0, 'h1FF, 'h01);
        check("R5 zero8 Z", (int'(ccr_o) >> 2) & 1, 1);
        // R7 add-with-carry uses held C=1
        do_op("R7 adc", 1, 0, 'h10, 'h20);
        check("R7 adc result", int'(result_o), 'h31);
        // R7 plain add ignores C: set C then add
        do_op("R3 carry set", 0, 1, 'hFFFF, 'h0002);
        do_op("R7 add ignores C", 0, 1, 'h1000, 'h0001);
        check("R7 add ignores C result", int'(result_o), 'h1001);
        // R6 16-bit add keeps H (H is 1 from earlier 8-bit add? model tracks)
        do_op("R6 h set", 0, 0, 'h0F, 'h01);
        do_op("R6 wide add keeps H", 0, 1, 'h0F0F, 'h0101);
        check("R6 H kept", (int'(ccr_o) >> 5) & 1, 1);
        do_op("R6 sub keeps H", 2, 0, 'h05, 'h03);
        check("R6 H kept sub", (int'(ccr_o) >> 5) & 1, 1);
        // R3 borrow and R4 subtract overflow
        do_op("R3 borrow", 2, 0, 'h03, 'h05);
        check("R3 borrow C", int'(ccr_o) & 1, 1);
        do_op("R7 sbc", 3, 0, 'h10, 'h01);
        check("R7 sbc result", int'(result_o), 'h0E);
        do_op("R4 sub ovf8", 2, 0, 'h80, 'h01);
        check("R4 sub ovf8 V", (int'(ccr_o) >> 1) & 1, 1);
        do_op("R4 sub ovf16", 2, 1, 'h8000, 'h0001);
        check("R4 sub ovf16 V", (int'(ccr_o) >> 1) & 1, 1);
        do_op("R4 add ovf8", 0, 0, 'h7F, 'h01);
        do_op("R5 zero16", 2, 1, 'h1234, 'h1234);
        idle("after zero16");
        // 32-bit chain: 0x0001FFFF + 0x00000001
        do_op("R7 chain lo", 0, 1, 'hFFFF, 'h0001);
        do_op("R7 chain hi", 1, 1, 'h0001, 'h0000);
        check("R7 chain hi result", int'(result_o), 'h0002);
        idle("after chain");

        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom_range(3, 0));
            int wd = int'($urandom_range(1, 0));
            if ($urandom_range(4, 0) == 0) idle("R9 random");
            else do_op("R2 R3 R4 R5 R6 random", op, wd, int'($urandom & 'hFFFF), int'($urandom & 'hFFFF));
        end
        check("R8 control bits", int'(ccr_o) & 'hD0, 'hD0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule